// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM with Staged Register Transfer

This block generates two pulse-width-modulated outputs, each driven by its own prescaler counter and period counter. Software sets up a channel through four word registers (control, prescaler, period, duty) in a per-channel window. A write first lands in a holding copy. It then passes through a fixed-latency transfer stage before it reaches the staged copy that the counting logic reads. A pending flag for each register shows the transfer in flight, and software polls that flag before it writes the next register.

The counting logic applies staged values in one of two ways. It can take them at once, or, in autoload mode, hold them back until the period counter wraps so that one waveform period never mixes old and new settings. A channel can be stopped gracefully at the end of its current period or halted at once. Two control bits restart the prescaler or period counter when a control value arrives. Polarity inversion is applied after all other output logic, so an idle channel rests at its inverted inactive level.

Top module: `syncpwm_top`

## Requirements
- R1: Channel c occupies byte offsets 16*c .. 16*c+15: control at +0x0 (6 bits), prescaler at +0x4 (10 bits), period at +0x8 (12 bits), duty at +0xC (12 bits). A read returns the last value written, masked to the field width, with upper bits zero.
- R2: A write to register r (control 0, prescaler 1, period 2, duty 3) of channel c sets bit 8*c+r of the status word at offset 0x40 on the next cycle. No status bit rises without a write.
- R3: The pending bit stays set for exactly XFER_LAT cycles after the write cycle (default 2) and then clears by itself. The transfer into the counting logic happens within that window.
- R4: While enabled (control bit 0), the output repeats every (prescaler+1)*(period+1) clocks and is active while the period count is below duty. Each period starts with the count at 0.
- R5: A duty of 0 keeps the output inactive, and a duty above the period value keeps it active in every cycle.
- R6: Control bit 1 inverts the output. A disabled channel shows the inactive level after inversion (0 plain, 1 inverted).
- R7: With autoload (control bit 2) set on a running channel, new prescaler, period and duty values take effect only from the first cycle after the period counter wraps.
- R8: With autoload clear, a transferred duty value takes effect one cycle after the transfer.
- R9: Clearing enable without control bit 3 lets the channel finish its current period before it goes idle.
- R10: Clearing enable with control bit 3 set stops the channel one cycle after the control transfer.
- R11: When a control value with bit 4 set is transferred, the prescaler counter restarts from 0. Bit 5 restarts the period counter from 0 in the same way.
- R12: Writes to the windows of channels 2 and 3 and to the status word are ignored and set no status bit. Reads of those channel windows return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | 7 | Byte address of the accessed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| pwmOut | output | 2 | One waveform output per channel |

## Verification
The bench sweeps every prescaler, period and duty combination of a small range. For each one it aligns on a rising edge and compares every output cycle over two periods with the arithmetic waveform, so an off-by-one in the wrap compare or in the duty compare shows up as a stretched period or an extra active cycle. Mid-period writes are placed at a known phase to separate autoload from immediate apply: a design that applied early would change the current period's pulse width. The same placement checks graceful stop against immediate stop and the two counter-restart bits, and a design that ignored a restart would keep its old phase. The bench also counts the pending flag cycle by cycle, probes the exact status bit positions for channel 1, and writes into the undecoded channel windows to catch a decoder that aliases them onto channels 0 and 1.

// File: rtl/syncpwm_pkg.sv
package syncpwm_pkg;

  localparam int CTL_W = 6;
  localparam int NUM_REGS = 4;

  localparam int BIT_EN     = 0;
  localparam int BIT_INV    = 1;
  localparam int BIT_AUTO   = 2;
  localparam int BIT_STOP   = 3;
  localparam int BIT_RSTPRE = 4;
  localparam int BIT_RSTPER = 5;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_PER  = 2'd2,
    SEL_DUTY = 2'd3
  } regSelT;

  typedef struct packed {
    logic duty;
    logic per;
    logic pre;
    logic ctl;
  } xferT;

endpackage

// File: rtl/syncpwm_regs.sv
module syncpwm_regs
  import syncpwm_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DEC_CH   = 4,
  parameter int PRE_W    = 10,
  parameter int PER_W    = 12,
  parameter int XFER_LAT = 2,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWe,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWdata,
  output logic [DATA_W-1:0]                busRdata,
  output xferT [NUM_CH-1:0]                xfer,
  output logic [NUM_CH-1:0][CTL_W-1:0]     ctlHold,
  output logic [NUM_CH-1:0][PRE_W-1:0]     preHold,
  output logic [NUM_CH-1:0][PER_W-1:0]     perHold,
  output logic [NUM_CH-1:0][PER_W-1:0]     dutyHold
);

  localparam int CH_IDX_W    = (DEC_CH > 1) ? $clog2(DEC_CH) : 1;
  localparam int STAT_OFS    = DEC_CH * 16;
  localparam int STAT_STRIDE = 8;
  localparam logic [XFER_LAT-1:0] EARLY_MASK = {XFER_LAT{1'b1}} >> 1;

  logic                statSel;
  logic                winSel;
  logic [CH_IDX_W-1:0] chIdx;
  logic [1:0]          regIdx;
  logic [DATA_W-1:0]   statusWord;

  logic [NUM_CH-1:0][NUM_REGS-1:0]               wrHit;
  logic [NUM_CH-1:0][NUM_REGS-1:0]               pending;
  logic [NUM_CH-1:0][NUM_REGS-1:0][XFER_LAT-1:0] pipeQ;

  logic unusedWdata;
  assign unusedWdata = ^busWdata[DATA_W-1:PER_W];

  assign statSel = (busAddr == ADDR_W'(STAT_OFS));
  assign winSel  = (busAddr <  ADDR_W'(STAT_OFS));
  assign chIdx   = busAddr[4 +: CH_IDX_W];
  assign regIdx  = busAddr[3:2];

  // write decode: only implemented channel windows produce a hit
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        wrHit[c][r] = busWe && winSel && (chIdx == CH_IDX_W'(c)) && (regIdx == 2'(r));
      end
    end
  end

  // holding copies
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlHold  <= '0;
      preHold  <= '0;
      perHold  <= '0;
      dutyHold <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wrHit[c][int'(SEL_CTL)])  ctlHold[c]  <= busWdata[CTL_W-1:0];
        if (wrHit[c][int'(SEL_PRE)])  preHold[c]  <= busWdata[PRE_W-1:0];
        if (wrHit[c][int'(SEL_PER)])  perHold[c]  <= busWdata[PER_W-1:0];
        if (wrHit[c][int'(SEL_DUTY)]) dutyHold[c] <= busWdata[PER_W-1:0];
      end
    end
  end

  // transfer pipeline and pending flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeQ   <= '0;
      pending <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          pipeQ[c][r] <= (pipeQ[c][r] << 1) | XFER_LAT'(wrHit[c][r]);
          if (wrHit[c][r]) begin
            pending[c][r] <= 1'b1;
          end else if (pipeQ[c][r][XFER_LAT-1] && !(|(pipeQ[c][r] & EARLY_MASK))) begin
            pending[c][r] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      xfer[c].ctl  = pipeQ[c][int'(SEL_CTL)][XFER_LAT-1];
      xfer[c].pre  = pipeQ[c][int'(SEL_PRE)][XFER_LAT-1];
      xfer[c].per  = pipeQ[c][int'(SEL_PER)][XFER_LAT-1];
      xfer[c].duty = pipeQ[c][int'(SEL_DUTY)][XFER_LAT-1];
    end
  end

  always_comb begin
    statusWord = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        statusWord[c*STAT_STRIDE + r] = pending[c][r];
      end
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (statSel) begin
      busRdata = statusWord;
    end else if (winSel) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chIdx == CH_IDX_W'(c)) begin
          case (regSelT'(regIdx))
            SEL_CTL:  busRdata = DATA_W'(ctlHold[c]);
            SEL_PRE:  busRdata = DATA_W'(preHold[c]);
            SEL_PER:  busRdata = DATA_W'(perHold[c]);
            default:  busRdata = DATA_W'(dutyHold[c]);
          endcase
        end
      end
    end
  end

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chk_ch
    for (genvar gr = 0; gr < NUM_REGS; gr++) begin : g_chk_reg
      AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        wrHit[gc][gr] |=> pending[gc][gr]) else $error("pending not raised"); // R2
      AST_PEND_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pending[gc][gr]) |-> $past(busWe)) else $error("pending without write"); // R2
      AST_XFER_WHILE_PEND: assert property (@(posedge clk) disable iff (!rstN)
        pipeQ[gc][gr][XFER_LAT-1] |-> pending[gc][gr]) else $error("transfer with no pending"); // R3
    end
  end

endmodule

// File: rtl/syncpwm_chan.sv
module syncpwm_chan
  import syncpwm_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferT              xfer,
  input  logic [CTL_W-1:0]  ctlHold,
  input  logic [PRE_W-1:0]  preHold,
  input  logic [PER_W-1:0]  perHold,
  input  logic [PER_W-1:0]  dutyHold,
  output logic              pwmOut
);

  logic [CTL_W-1:0] ctlStg;
  logic [PRE_W-1:0] preStg, preAct, preCnt;
  logic [PER_W-1:0] perStg, perAct, perCnt;
  logic [PER_W-1:0] dutyStg, dutyAct;
  logic             running;

  logic en, inv, autoLd, stopImm;
  logic preEnd, wrapNow, applyNow, rawOn;

  logic unusedCtl;
  assign unusedCtl = ^ctlStg[BIT_RSTPER:BIT_RSTPRE];

  assign en      = ctlStg[BIT_EN];
  assign inv     = ctlStg[BIT_INV];
  assign autoLd  = ctlStg[BIT_AUTO];
  assign stopImm = ctlStg[BIT_STOP];

  assign preEnd   = (preCnt >= preAct);
  assign wrapNow  = running && preEnd && (perCnt >= perAct);
  assign applyNow = !autoLd || !running || wrapNow;

  // staged copies fed by the transfer strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlStg  <= '0;
      preStg  <= '0;
      perStg  <= '0;
      dutyStg <= '0;
    end else begin
      if (xfer.ctl)  ctlStg  <= ctlHold;
      if (xfer.pre)  preStg  <= preHold;
      if (xfer.per)  perStg  <= perHold;
      if (xfer.duty) dutyStg <= dutyHold;
    end
  end

  // active copies used by the counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preAct  <= '0;
      perAct  <= '0;
      dutyAct <= '0;
    end else if (applyNow) begin
      preAct  <= preStg;
      perAct  <= perStg;
      dutyAct <= dutyStg;
    end
  end

  // prescaler and period counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
      perCnt  <= '0;
    end else if (!running) begin
      preCnt <= '0;
      perCnt <= '0;
      if (en) running <= 1'b1;
    end else if (!en && stopImm) begin
      running <= 1'b0;
      preCnt  <= '0;
      perCnt  <= '0;
    end else begin
      if (wrapNow) begin
        preCnt <= '0;
        perCnt <= '0;
        if (!en) running <= 1'b0;
      end else if (preEnd) begin
        preCnt <= '0;
        perCnt <= perCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (xfer.ctl && ctlHold[BIT_RSTPRE]) preCnt <= '0;
      if (xfer.ctl && ctlHold[BIT_RSTPER]) perCnt <= '0;
    end
  end

  assign rawOn  = running && (perCnt < dutyAct);
  assign pwmOut = rawOn ^ inv;

  AST_IDLE_COUNTS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (preCnt == '0) && (perCnt == '0)) else $error("idle counters"); // R9
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (pwmOut == inv)) else $error("idle level"); // R6
  AST_HOLD_TILL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    running && autoLd && !wrapNow |=> $stable(dutyAct) && $stable(perAct) && $stable(preAct))
    else $error("autoload applied mid-period"); // R7
  AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rstN)
    running && !en && stopImm |=> !running) else $error("immediate stop late"); // R10
  AST_FINISH_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    running && !en && !stopImm && !wrapNow |=> running) else $error("graceful stop early"); // R9

endmodule

// File: rtl/syncpwm_top.sv
module syncpwm_top
  import syncpwm_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DEC_CH   = 4,
  parameter int PRE_W    = 10,
  parameter int PER_W    = 12,
  parameter int XFER_LAT = 2,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] pwmOut
);

  xferT [NUM_CH-1:0]             xferBus;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctlHold;
  logic [NUM_CH-1:0][PRE_W-1:0]  preHold;
  logic [NUM_CH-1:0][PER_W-1:0]  perHold;
  logic [NUM_CH-1:0][PER_W-1:0]  dutyHold;

  syncpwm_regs #(
    .NUM_CH(NUM_CH), .DEC_CH(DEC_CH), .PRE_W(PRE_W), .PER_W(PER_W),
    .XFER_LAT(XFER_LAT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .xfer     (xferBus),
    .ctlHold  (ctlHold),
    .preHold  (preHold),
    .perHold  (perHold),
    .dutyHold (dutyHold)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    syncpwm_chan #(.PRE_W(PRE_W), .PER_W(PER_W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .xfer     (xferBus[gc]),
      .ctlHold  (ctlHold[gc]),
      .preHold  (preHold[gc]),
      .perHold  (perHold[gc]),
      .dutyHold (dutyHold[gc]),
      .pwmOut   (pwmOut[gc])
    );
  end

endmodule

// File: tb/test_syncpwm_top.sv
`timescale 1ns/1ps
module test_syncpwm_top;

  localparam int XFER_LAT = 2;
  localparam logic [6:0] STAT = 7'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  pwmOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  syncpwm_top i_syncpwm_top (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int k = 0; k < 64; k++) begin
      rd(STAT, v);
      if (v == 0) return;
      @(negedge clk);
    end
    check("R3 pending never cleared", v, 32'h0);
  endtask

  task automatic cfg(input int ch, input int pre, input int per, input int duty, input int ctl);
    logic [6:0] base;
    base = 7'(ch * 16);
    wr(base + 7'h4, pre);  waitIdle();
    wr(base + 7'h8, per);  waitIdle();
    wr(base + 7'hC, duty); waitIdle();
    wr(base, ctl);         waitIdle();
  endtask

  task automatic alignRise(input int ch, output bit found);
    logic prev;
    found = 1'b0;
    prev = pwmOut[ch];
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!prev && pwmOut[ch]) begin
        found = 1'b1;
        return;
      end
      prev = pwmOut[ch];
    end
  endtask

  function automatic logic expPhase(input int tid, input int ph);
    case (tid)
      0: return (ph < 8) ? (ph < 2) : ((ph % 8) < 6);            // autoload
      1: return (ph < 4) ? ((ph % 8) < 2) : ((ph % 8) < 6);      // immediate
      2: return (ph < 8) ? (ph < 7) : 1'b0;                      // graceful stop
      3: return (ph < 4) ? (ph < 7) : 1'b0;                      // immediate stop
      4: return (ph < 3) ? (ph < 4) : (((ph - 3) % 8) < 4);      // period restart
      default: return (ph < 3) ? 1'b1 : ((((ph - 3) % 8) / 4) < 1); // prescaler restart
    endcase
  endfunction

  task automatic phaseTest(input string req, input int tid, input int pre, input int per,
                           input int duty, input int ctl, input logic [6:0] ofs,
                           input logic [31:0] val);
    bit found;
    int mism;
    cfg(0, pre, per, duty, ctl);
    repeat (12) @(negedge clk);
    alignRise(0, found);
    check({req, " align"}, 32'(found), 32'h1);
    wr(ofs, val);
    mism = 0;
    for (int ph = 1; ph < 24; ph++) begin
      if (pwmOut[0] !== expPhase(tid, ph)) mism++;
      @(negedge clk);
    end
    check(req, mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit found;
    int bad, ones, per2;

    // reset state
    repeat (3) @(negedge clk);
    check("R1 reset out", 32'(pwmOut), 32'h0);
    rd(7'h00, v); check("R1 reset ctl", v, 32'h0);
    rd(STAT, v);  check("R2 reset status", v, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 readback and masking on channel 1
    wr(7'h10, 32'hF6);    waitIdle();
    wr(7'h14, 32'hFFFF);  waitIdle();
    wr(7'h18, 32'hFFFFF); waitIdle();
    wr(7'h1C, 32'hABCDE); waitIdle();
    rd(7'h10, v); check("R1 ctl", v, 32'h36);
    rd(7'h14, v); check("R1 prescaler", v, 32'h3FF);
    rd(7'h18, v); check("R1 period", v, 32'hFFF);
    rd(7'h1C, v); check("R1 duty", v, 32'hCDE);
    repeat (2) @(negedge clk);
    check("R6 idle inverted level", 32'(pwmOut[1]), 32'h1);

    // R2/R3 pending position and duration, channel 1 duty -> bit 11
    wr(7'h1C, 32'h5);
    for (int k = 1; k <= XFER_LAT; k++) begin
      rd(STAT, v); check("R3 pending held", v, 32'h800);
      @(negedge clk);
    end
    rd(STAT, v); check("R3 pending cleared", v, 32'h0);
    wr(7'h04, 32'h1);
    rd(STAT, v); check("R2 ch0 prescaler bit", v, 32'h2);
    waitIdle();

    // R12 ignored windows
    wr(7'h20, 32'h3F);
    rd(STAT, v); check("R12 ch2 write no status", v, 32'h0);
    wr(7'h34, 32'h5);
    rd(STAT, v); check("R12 ch3 write no status", v, 32'h0);
    wr(STAT, 32'hFF);
    rd(STAT, v); check("R12 status write ignored", v, 32'h0);
    rd(7'h20, v); check("R12 ch2 read zero", v, 32'h0);
    rd(7'h34, v); check("R12 ch3 read zero", v, 32'h0);
    rd(7'h10, v); check("R12 ch1 ctl untouched", v, 32'h36);
    check("R12 ch1 output untouched", 32'(pwmOut[1]), 32'h1);

    // R6 inverted running output on channel 1
    cfg(1, 0, 3, 1, 3);
    repeat (8) @(negedge clk);
    ones = 0;
    for (int k = 0; k < 4; k++) begin
      ones += int'(pwmOut[1]);
      @(negedge clk);
    end
    check("R6 inverted high count", ones, 3);

    // R4/R5 sweep on channel 0
    for (int pre = 0; pre < 3; pre++) begin
      for (int per = 0; per < 4; per++) begin
        for (int duty = 0; duty < 6; duty++) begin
          per2 = (pre + 1) * (per + 1);
          cfg(0, pre, per, duty, 1);
          repeat (per2 + 4) @(negedge clk);
          bad = 0;
          if (duty > 0 && duty <= per) begin
            alignRise(0, found);
            if (!found) bad++;
            for (int i = 0; i < 2 * per2; i++) begin
              if (i > 0) @(negedge clk);
              if (pwmOut[0] !== (((i % per2) / (pre + 1)) < duty)) bad++;
            end
            check("R4 waveform", bad, 0);
          end else begin
            for (int i = 0; i < per2; i++) begin
              if (pwmOut[0] !== (duty != 0)) bad++;
              @(negedge clk);
            end
            check("R5 constant level", bad, 0);
          end
        end
      end
    end

    // phase-placed mid-period writes
    phaseTest("R7 autoload at wrap",      0, 0, 7, 2, 5, 7'h0C, 32'h6);
    phaseTest("R8 immediate apply",       1, 0, 7, 2, 1, 7'h0C, 32'h6);
    phaseTest("R9 graceful stop",         2, 0, 7, 7, 1, 7'h00, 32'h0);
    phaseTest("R10 immediate stop",       3, 0, 7, 7, 1, 7'h00, 32'h8);
    phaseTest("R11 period restart",       4, 0, 7, 4, 1, 7'h00, 32'h21);
    phaseTest("R11 prescaler restart",    5, 3, 1, 1, 1, 7'h00, 32'h11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule